// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial EEPROM that an external controller reaches through a chip select, a serial clock, a serial data input and a serial data output with its own output enable. Every transfer begins with a start bit, followed by a two-bit opcode and an address, all captured on rising edges of the serial clock. Write-type transfers then carry one data word. Reads return a leading zero and then the stored word, most significant bit first. The storage is an array of registers.

Every command that changes the memory is gated by a write-enable latch. That latch is cleared by reset and changed only by the unlock and lock commands. When a modifying command has been fully shifted in, it is held until chip select falls. The falling edge starts a programming cycle of fixed length that runs on the system clock, and no serial clocks are needed while it runs. While chip select is high, the output reports the state of this cycle: low while it runs and high once it is done. A new start bit returns the output to standby.

The serial lines are sampled by the system clock. A serial clock edge is detected by comparing each sample with the one taken in the previous cycle.

Top module: `mw_serial_eeprom`

## Requirements
- R1: After reset the output enable is low and the write-enable latch is clear. Until an unlock command arrives, the word write, word erase, fill-all and erase-all commands start no programming cycle and leave the memory unchanged.
- R2: Extended opcode 00 uses the two top address bits as a sub-code: 11 sets the write-enable latch and 00 clears it. Once set, the latch stays set until it is cleared or reset is applied.
- R3: Opcode 10 reads a word, and it works whatever the state of the latch. On the serial clock rise that samples the last address bit, the output starts driving a 0. Each further rise presents the next data bit, most significant bit first. Once the word has been sent, the output stays at 0.
- R4: Opcode 01 is followed by the address and then DATA_W data bits, both most significant bit first. The word is stored at the address when chip select falls after the frame is complete.
- R5: Opcode 11 with an address sets every bit of that word to 1 and leaves all other words alone.
- R6: Sub-code 10 sets every bit of every word to 1. Sub-code 01 is followed by a data word, and that word is written to every location.
- R7: The programming cycle begins on the falling edge of chip select and lasts exactly PROG_CYCLES system clocks, whether or not the serial clock toggles.
- R8: Once a programming cycle has started, the output is enabled whenever chip select is high. It drives 0 while the cycle runs and 1 after it ends, until a start bit is sampled. The output enable is low whenever chip select is low.
- R9: While a programming cycle runs, serial clock rises are ignored, so a command sent during that time has no effect.
- R10: If chip select falls before a frame is complete, the command is dropped and the memory does not change.
- R11: Serial clock rises that sample a 0 before the start bit are skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Device select, active high |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edges |
| ser_in | input | 1 | Serial command, address and data input |
| ser_out | output | 1 | Serial read data or ready/busy status |
| ser_out_en | output | 1 | High when ser_out is driven; low means high-Z |

## Verification
The assertions assume that chip select, serial clock and serial input change in step with the system clock. They also assume that each serial clock level lasts at least two system clocks, and that chip select is never lowered in the cycle right after the clock rise that completes a frame. The stimulus changes the serial lines only on falling edges of the system clock. It holds every serial clock level for three system clocks and waits two clocks before lowering chip select. Under these conditions every command is decoded before the select edge that might start programming it. A behavioural model in the testbench follows the same protocol, and its results are compared with the outputs on every clock.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_OPC,
    FR_ADR,
    FR_DAT,
    FR_DONE
  } frame_st_e;

  typedef enum logic [1:0] {
    PG_WORD,
    PG_CLEAR,
    PG_FILL,
    PG_WIPE
  } prog_kind_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_WIPE   = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/mwe_frame_rx.sv
module mwe_frame_rx
  import mwe_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk_rise,
  input  logic              di,
  input  logic              busy,
  output logic              start_det,
  output logic              cmd_vld,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  localparam int MAXLEN = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  frame_st_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [1:0]         op_q, op_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               vld_q, vld_d;
  logic               need_data;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    op_d      = op_q;
    addr_d    = addr_q;
    data_d    = data_q;
    vld_d     = 1'b0;
    start_det = 1'b0;
    need_data = 1'b0;
    if (!cs) begin
      st_d = FR_IDLE;
    end else if (sk_rise && !busy) begin
      unique case (st_q)
        FR_IDLE: begin
          if (di) begin
            st_d      = FR_OPC;
            cnt_d     = '0;
            start_det = 1'b1;
          end
        end
        FR_OPC: begin
          op_d = {op_q[0], di};
          if (cnt_q == CNT_W'(1)) begin
            st_d  = FR_ADR;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        FR_ADR: begin
          addr_d    = {addr_q[ADDR_W-2:0], di};
          need_data = (op_q == OPC_WRITE) ||
                      ((op_q == OPC_EXT) && (addr_d[ADDR_W-1 -: 2] == EXT_FILL));
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            cnt_d = '0;
            if (need_data) begin
              st_d = FR_DAT;
            end else begin
              st_d  = FR_DONE;
              vld_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        FR_DAT: begin
          data_d = {data_q[DATA_W-2:0], di};
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            st_d  = FR_DONE;
            vld_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign cmd_vld  = vld_q;
  assign cmd_op   = op_q;
  assign cmd_addr = addr_q;
  assign cmd_data = data_q;

  AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !cmd_vld); // R9
  AST_ABORT_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !cmd_vld); // R10

endmodule

// File: rtl/mwe_prog_timer.sv
module mwe_prog_timer #(
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = TW'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < TW'(PROG_CYCLES))); // R7

endmodule

// File: rtl/mwe_word_array.sv
module mwe_word_array
  import mwe_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              prog_en,
  input  prog_kind_e        prog_kind,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] wr_val;
  logic              wr_all;

  always_comb begin
    wr_all = (prog_kind == PG_FILL) || (prog_kind == PG_WIPE);
    wr_val = ((prog_kind == PG_CLEAR) || (prog_kind == PG_WIPE)) ? '1 : prog_data;
  end

  always_ff @(posedge clk) begin
    if (prog_en) begin
      for (int i = 0; i < WORDS; i++) begin
        if (wr_all || (i == int'(prog_addr))) begin
          mem_q[i] <= wr_val;
        end
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/mw_serial_eeprom.sv
module mw_serial_eeprom
  import mwe_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_out_en
);

  logic              cs_q, sk_q;
  logic              sk_rise, cs_fall, prog_go;
  logic              busy, start_det, cmd_vld;
  logic [1:0]        cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data, rd_data;

  logic              wel_q, wel_d;
  logic              pend_q, pend_d;
  prog_kind_e        kind_q, kind_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic [DATA_W-1:0] pdata_q, pdata_d;
  logic              rd_on_q, rd_on_d;
  logic [DATA_W:0]   rd_sr_q, rd_sr_d;
  logic              stat_q, stat_d;

  assign sk_rise = ser_clk & ~sk_q;
  assign cs_fall = cs_q & ~chip_sel;
  assign prog_go = cs_fall & pend_q;

  mwe_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (chip_sel),
    .sk_rise  (sk_rise),
    .di       (ser_in),
    .busy     (busy),
    .start_det(start_det),
    .cmd_vld  (cmd_vld),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data)
  );

  mwe_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(prog_go),
    .busy (busy)
  );

  mwe_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .prog_en  (prog_go),
    .prog_kind(kind_q),
    .prog_addr(paddr_q),
    .prog_data(pdata_q),
    .rd_addr  (cmd_addr),
    .rd_data  (rd_data)
  );

  always_comb begin
    wel_d   = wel_q;
    pend_d  = pend_q;
    kind_d  = kind_q;
    paddr_d = paddr_q;
    pdata_d = pdata_q;
    rd_on_d = rd_on_q;
    rd_sr_d = rd_sr_q;
    stat_d  = stat_q;
    if (cmd_vld) begin
      paddr_d = cmd_addr;
      pdata_d = cmd_data;
      unique case (cmd_op)
        OPC_READ: begin
          rd_on_d = 1'b1;
          rd_sr_d = {1'b0, rd_data};
        end
        OPC_WRITE: begin
          pend_d = wel_q;
          kind_d = PG_WORD;
        end
        OPC_ERASE: begin
          pend_d = wel_q;
          kind_d = PG_CLEAR;
        end
        default: begin
          unique case (cmd_addr[ADDR_W-1 -: 2])
            EXT_LOCK:   wel_d = 1'b0;
            EXT_UNLOCK: wel_d = 1'b1;
            EXT_FILL: begin
              pend_d = wel_q;
              kind_d = PG_FILL;
            end
            default: begin
              pend_d = wel_q;
              kind_d = PG_WIPE;
            end
          endcase
        end
      endcase
    end else if (rd_on_q && sk_rise) begin
      rd_sr_d = {rd_sr_q[DATA_W-1:0], 1'b0};
    end
    if (!chip_sel) begin
      rd_on_d = 1'b0;
      pend_d  = 1'b0;
    end
    if (prog_go) begin
      stat_d = 1'b1;
    end else if (start_det) begin
      stat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      wel_q   <= 1'b0;
      pend_q  <= 1'b0;
      kind_q  <= PG_WORD;
      paddr_q <= '0;
      pdata_q <= '0;
      rd_on_q <= 1'b0;
      rd_sr_q <= '0;
      stat_q  <= 1'b0;
    end else begin
      cs_q    <= chip_sel;
      sk_q    <= ser_clk;
      wel_q   <= wel_d;
      pend_q  <= pend_d;
      kind_q  <= kind_d;
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
      rd_on_q <= rd_on_d;
      rd_sr_q <= rd_sr_d;
      stat_q  <= stat_d;
    end
  end

  assign ser_out_en = cs_q & (rd_on_q | stat_q);
  assign ser_out    = rd_on_q ? rd_sr_q[DATA_W] : ~busy;

  AST_PROG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pend_q)); // R1
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> $stable(wel_q)); // R2
  AST_READ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_on_q |-> !busy); // R9

endmodule

// File: tb/mw_serial_eeprom_tb.sv
module mw_serial_eeprom_tb;

  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int PROG  = 400;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic cs, sk, di;
  logic ser_out, ser_out_en;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  mw_serial_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_sel  (cs),
    .ser_clk   (sk),
    .ser_in    (di),
    .ser_out   (ser_out),
    .ser_out_en(ser_out_en)
  );

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] mm [WORDS];
  logic m_wel, m_pend, m_stat, m_rd_on, m_started, m_done, m_act;
  logic m_sk_prev, m_cs_prev;
  int   m_busy_left;
  int   m_pkind, m_paddr;
  logic [DW-1:0] m_pdata;
  logic fq[$];
  logic rdq[$];
  logic [1:0] a_op, a_ext;
  int   a_addr;
  logic [DW-1:0] a_data;

  task automatic arm(input int kind);
    if (m_wel) begin
      m_pend  = 1'b1;
      m_pkind = kind;
      m_paddr = a_addr;
      m_pdata = a_data;
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      m_wel = 0; m_pend = 0; m_stat = 0; m_rd_on = 0; m_started = 0;
      m_done = 0; m_act = 0; m_sk_prev = 0; m_cs_prev = 0; m_busy_left = 0;
      fq.delete(); rdq.delete();
    end else begin
      logic skr, csf, was_busy, pend_old, exp_oe, exp_val;
      skr      = sk && !m_sk_prev;
      csf      = m_cs_prev && !cs;
      was_busy = (m_busy_left > 0);
      pend_old = m_pend;
      if (m_act) begin
        m_act = 0;
        case (a_op)
          2'b10: begin
            rdq.delete();
            rdq.push_back(1'b0);
            for (int i = DW - 1; i >= 0; i--) rdq.push_back(mm[a_addr][i]);
            m_rd_on = 1;
          end
          2'b01: arm(0);
          2'b11: arm(1);
          default: begin
            if (a_ext == 2'b00) m_wel = 0;
            else if (a_ext == 2'b11) m_wel = 1;
            else if (a_ext == 2'b01) arm(2);
            else arm(3);
          end
        endcase
      end else if (m_rd_on && skr) begin
        if (rdq.size() > 0) void'(rdq.pop_front());
      end
      if (!cs) begin
        m_started = 0; m_done = 0; fq.delete();
      end else if (skr && !was_busy) begin
        if (!m_started) begin
          if (di) begin m_started = 1; m_stat = 0; end
        end else if (!m_done) begin
          int n;
          logic need;
          fq.push_back(di);
          n = fq.size();
          if (n >= 2 + AW) begin
            a_op  = {fq[0], fq[1]};
            a_ext = {fq[2], fq[3]};
            need  = (a_op == 2'b01) || (a_op == 2'b00 && a_ext == 2'b01);
            if ((!need && n == 2 + AW) || (need && n == 2 + AW + DW)) begin
              m_done = 1; m_act = 1;
              a_addr = 0;
              for (int i = 0; i < AW; i++) a_addr = a_addr * 2 + int'(fq[2 + i]);
              a_data = '0;
              if (need) for (int i = 0; i < DW; i++) a_data = {a_data[DW-2:0], fq[2 + AW + i]};
            end
          end
        end
      end
      if (csf && pend_old) begin
        case (m_pkind)
          0: mm[m_paddr] = m_pdata;
          1: mm[m_paddr] = '1;
          2: for (int i = 0; i < WORDS; i++) mm[i] = m_pdata;
          default: for (int i = 0; i < WORDS; i++) mm[i] = '1;
        endcase
        m_busy_left = PROG;
        m_stat = 1;
      end else if (m_busy_left > 0) begin
        m_busy_left--;
      end
      if (!cs) begin m_rd_on = 0; m_pend = 0; end
      m_sk_prev = sk;
      m_cs_prev = cs;
      exp_oe  = cs && (m_rd_on || m_stat);
      exp_val = m_rd_on ? ((rdq.size() > 0) ? rdq[0] : 1'b0) : (m_busy_left == 0);
      n_chk++;
      if (ser_out_en !== exp_oe || (exp_oe && ser_out !== exp_val)) begin
        n_err++;
        $display("FAIL %s per-clock compare: oe=%b out=%b expected oe=%b out=%b",
                 cur_req, ser_out_en, ser_out, exp_oe, exp_val);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    di = b; sk = 1'b0; tick(3);
    sk = 1'b1; tick(3);
  endtask

  task automatic cs_on();
    sk = 1'b0; cs = 1'b1; tick(3);
  endtask

  task automatic cs_off();
    sk = 1'b0; tick(2);
    cs = 1'b0; tick(3);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] addr);
    sk_bit(1'b1);
    sk_bit(op[1]);
    sk_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) sk_bit(addr[i]);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] addr,
                          input bit has_data, input logic [DW-1:0] data);
    cs_on();
    send_hdr(op, addr);
    if (has_data) for (int i = DW - 1; i >= 0; i--) sk_bit(data[i]);
    cs_off();
  endtask

  task automatic ext_cmd(input logic [1:0] code, input bit has_data, input logic [DW-1:0] data);
    send_cmd(2'b00, {code, {(AW-2){1'b0}}}, has_data, data);
  endtask

  task automatic wait_ready();
    int guard;
    guard = 0;
    cs_on();
    while (!(ser_out_en === 1'b1 && ser_out === 1'b1) && guard < 3 * PROG) begin
      tick(1);
      guard++;
    end
    check("R8 ready seen", 32'(guard < 3 * PROG), 32'd1);
    cs_off();
  endtask

  task automatic read_word(input string req, input logic [AW-1:0] addr,
                           input int lead_zeros, input logic [DW-1:0] exp);
    logic [DW-1:0] got;
    got = '0;
    cs_on();
    for (int i = 0; i < lead_zeros; i++) sk_bit(1'b0);
    send_hdr(2'b10, addr);
    for (int i = 0; i <= DW; i++) begin
      sk = 1'b0; tick(3);
      if (i == 0) check("R3 dummy zero", {30'd0, ser_out_en, ser_out}, 32'b10);
      else got = {got[DW-2:0], ser_out};
      sk = 1'b1; tick(3);
    end
    sk = 1'b0; tick(3);
    check("R3 trailing zero", {31'd0, ser_out}, 32'd0);
    cs_off();
    check(req, 32'(got), 32'(exp));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // ---------------- scenario ----------------
  initial begin
    int cnt;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    cur_req = "R1";
    check("R1 reset output disabled", 32'(ser_out_en), 32'd0);

    // erase-all while locked: nothing starts
    ext_cmd(2'b10, 0, '0);
    cs_on();
    check("R1 locked erase-all starts no cycle", 32'(ser_out_en), 32'd0);
    cs_off();

    cur_req = "R2";
    ext_cmd(2'b11, 0, '0);

    // erase-all and measure the busy window
    cur_req = "R7";
    ext_cmd(2'b10, 0, '0);
    cs_on();
    check("R8 busy status low", {30'd0, ser_out_en, ser_out}, 32'b10);
    cnt = 0;
    while (ser_out !== 1'b1 && cnt < 2 * PROG) begin
      tick(1);
      cnt++;
    end
    check("R7 busy length", 32'(cnt), 32'(PROG - 5));
    check("R8 ready status high", {30'd0, ser_out_en, ser_out}, 32'b11);
    cs_off();
    check("R8 output disabled when deselected", 32'(ser_out_en), 32'd0);

    cur_req = "R6";
    read_word("R6 erase-all word 3", 10'd3, 0, 16'hFFFF);
    read_word("R6 erase-all word 1023", 10'd1023, 0, 16'hFFFF);
    cs_on();
    check("R8 start bit returned to standby", 32'(ser_out_en), 32'd0);
    cs_off();

    cur_req = "R4";
    send_cmd(2'b01, 10'd3, 1, 16'hA5C3);
    wait_ready();
    read_word("R4 write word 3", 10'd3, 0, 16'hA5C3);

    cur_req = "R7";
    send_cmd(2'b01, 10'd1023, 1, 16'h1234);
    tick(PROG + 5);
    cs_on();
    check("R7 cycle ends without serial clocks", {30'd0, ser_out_en, ser_out}, 32'b11);
    cs_off();
    read_word("R4 write top word", 10'd1023, 0, 16'h1234);

    cur_req = "R5";
    send_cmd(2'b11, 10'd3, 0, '0);
    wait_ready();
    read_word("R5 erased word 3", 10'd3, 0, 16'hFFFF);
    read_word("R5 other word kept", 10'd1023, 0, 16'h1234);

    cur_req = "R6";
    ext_cmd(2'b01, 1, 16'h0F0F);
    wait_ready();
    read_word("R6 fill word 0", 10'd0, 0, 16'h0F0F);
    read_word("R6 fill word 1023", 10'd1023, 0, 16'h0F0F);

    cur_req = "R2";
    ext_cmd(2'b00, 0, '0);
    send_cmd(2'b01, 10'd0, 1, 16'h0000);
    cs_on();
    check("R2 locked write starts no cycle", 32'(ser_out_en), 32'd0);
    cs_off();
    cur_req = "R3";
    read_word("R3 read while locked", 10'd0, 0, 16'h0F0F);

    cur_req = "R10";
    ext_cmd(2'b11, 0, '0);
    cs_on();
    send_hdr(2'b01, 10'd9);
    for (int i = 0; i < 5; i++) sk_bit(1'b1);
    cs_off();
    cs_on();
    check("R10 aborted write starts no cycle", 32'(ser_out_en), 32'd0);
    cs_off();
    read_word("R10 aborted word unchanged", 10'd9, 0, 16'h0F0F);

    cur_req = "R9";
    send_cmd(2'b01, 10'd7, 1, 16'h1111);
    send_cmd(2'b01, 10'd8, 1, 16'h2222);
    wait_ready();
    read_word("R9 command during busy ignored", 10'd8, 0, 16'h0F0F);

    cur_req = "R11";
    read_word("R11 leading zeros skipped", 10'd7, 2, 16'h1111);

    tick(5);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule